// File: doc/BRIEF.md
# MDIO Management Master

This block runs serial management transactions toward an Ethernet PHY. The host loads one 32-bit word into the frame register. The word holds the start pattern, the opcode, the PHY address, the register address, the turnaround pattern and a 16-bit data field. The write launches a transaction at once. The block sends 32 preamble ones and then the frame word MSB first on the management data line, clocked by a management clock that it generates itself. In a read, the block releases the data line from the turnaround onward and shifts in 16 bits returned by the PHY. At the end of the frame those bits replace the low half of the frame register.

The management clock runs only while a frame is in progress. Its half period equals the programmed speed value in system clock cycles, and a speed of 0 freezes it low. Software normally programs speed as (system clock in MHz / 5) + 1, which keeps the clock at or below about 2.5 MHz.

Completion sets an event flag that software clears by writing one to it. An interrupt mask bit decides whether the flag reaches the interrupt output. The data line is exposed as separate output, output-enable and input pins, to be joined at a pad.

Top module: `phy_mgmt_master`

## Requirements
- R1: A frame is 64 management clock periods: 32 ones, then frame_wdata bits 31 down to 0, with bits [31:30] start, [29:28] opcode, [27:23] PHY address, [22:18] register address, [17:16] turnaround and [15:0] data.
- R2: A frame_wr pulse while idle starts a frame, and busy reads 1 from the next cycle until the frame ends.
- R3: mdc is low whenever no frame is running and whenever speed is 0. During a frame with speed S > 0, each mdc high and low phase lasts exactly S clock cycles.
- R4: mdio_o and mdio_oe change only while mdc is low, which is after its falling edge. mdio_i is sampled at the rising edge of mdc.
- R5: With opcode 2'b10 (read), mdio_oe is 0 for the last 18 bit times (turnaround and data). With any other opcode, mdio_oe stays 1 for all 64 bits. Outside a frame, mdio_oe is 0.
- R6: After a read, frame_q[15:0] holds the 16 bits sampled in the data bit times, first sampled bit in bit 15, and frame_q[31:16] is unchanged. After any other opcode, frame_q equals the word written.
- R7: evt_flag becomes 1 in the same cycle that busy falls at the end of a frame, and a one-cycle evt_clear pulse clears it.
- R8: irq is 1 exactly when evt_flag and irq_mask are both 1. With irq_mask at 0, evt_flag still sets.
- R9: A frame_wr pulse while busy is ignored: the frame on the line and frame_q are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_wr | input | 1 | Write strobe for the frame register |
| frame_wdata | input | 32 | Frame word to load |
| speed | input | SPEED_W | Management clock half period in system cycles, 0 stops the clock |
| evt_clear | input | 1 | Write-one-to-clear pulse for the event flag |
| irq_mask | input | 1 | 1 lets the event flag drive irq |
| mdio_i | input | 1 | Management data line, input side |
| frame_q | output | 32 | Frame register contents, including read data |
| busy | output | 1 | A frame is in progress |
| evt_flag | output | 1 | Frame completion event |
| irq | output | 1 | Masked completion interrupt |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data line, output value |
| mdio_oe | output | 1 | Management data line, output enable |

## Verification
Writes with different address and data patterns and with speeds of 1 and 3 show whether each field reaches the line in the right position and order, and whether the clock phase length follows the speed value. A read whose returned data has asymmetric bits shows the direction of the capture shift, the exact line-release window and whether the upper half of the register is preserved. A write issued in the middle of a frame separates a design that ignores it from one that reloads or corrupts the frame. A frame started at speed 0 and resumed later shows that the clock is held low and that the transfer is not lost. The mask is toggled after the event has set to show that the flag and the interrupt are separate.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_W  = 32;
  localparam int PRE_LEN  = 32;
  localparam int DATA_W   = 16;
  localparam int TA_BITS  = 2;
  localparam int BIT_CNT  = PRE_LEN + FRAME_W;
  localparam int IDX_W    = $clog2(BIT_CNT);
  localparam int FIDX_W   = $clog2(FRAME_W);
  localparam int REL_IDX  = BIT_CNT - DATA_W - TA_BITS;
  localparam int CAP_IDX  = BIT_CNT - DATA_W;
  localparam logic [1:0] OP_READ = 2'b10;
endpackage

// File: rtl/mdc_gen.sv
module mdc_gen #(
  parameter int SPEED_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [SPEED_W-1:0] speed,
  output logic               mdc,
  output logic               rise_tick,
  output logic               fall_tick
);
  logic [SPEED_W-1:0] cnt_q, cnt_d;
  logic               mdc_q, mdc_d;

  always_comb begin
    cnt_d     = cnt_q;
    mdc_d     = mdc_q;
    rise_tick = 1'b0;
    fall_tick = 1'b0;
    if (!run || speed == '0) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (cnt_q >= speed - SPEED_W'(1)) begin
      cnt_d     = '0;
      mdc_d     = !mdc_q;
      rise_tick = !mdc_q;
      fall_tick = mdc_q;
    end else begin
      cnt_d = cnt_q + SPEED_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc = mdc_q;
endmodule

// File: rtl/frame_engine.sv
module frame_engine
  import mdio_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] wdata,
  input  logic               rise_tick,
  input  logic               fall_tick,
  input  logic               mdio_i,
  output logic               busy,
  output logic [FRAME_W-1:0] frame_q,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic               done
);
  logic               busy_q, busy_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [FRAME_W-1:0] frm_q, frm_d;
  logic [DATA_W-1:0]  rd_q, rd_d;
  logic               is_read, released, cap_win, last_bit;
  logic [FIDX_W-1:0]  fsel;
  logic               cur_bit;

  assign is_read  = (frm_q[FRAME_W-3 -: 2] == OP_READ);
  assign released = is_read && (idx_q >= IDX_W'(REL_IDX));
  assign cap_win  = idx_q >= IDX_W'(CAP_IDX);
  assign last_bit = idx_q == IDX_W'(BIT_CNT - 1);
  assign fsel     = FIDX_W'(IDX_W'(BIT_CNT - 1) - idx_q);
  assign cur_bit  = (idx_q < IDX_W'(PRE_LEN)) ? 1'b1 : frm_q[fsel];

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    frm_d  = frm_q;
    rd_d   = rd_q;
    done   = 1'b0;
    if (start && !busy_q) begin
      busy_d = 1'b1;
      idx_d  = '0;
      frm_d  = wdata;
    end else if (busy_q) begin
      if (rise_tick && cap_win) begin
        rd_d = {rd_q[DATA_W-2:0], mdio_i};
      end
      if (fall_tick) begin
        if (last_bit) begin
          busy_d = 1'b0;
          done   = 1'b1;
          if (is_read) begin
            frm_d[DATA_W-1:0] = rd_q;
          end
        end else begin
          idx_d = idx_q + IDX_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      frm_q  <= '0;
      rd_q   <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      frm_q  <= frm_d;
      rd_q   <= rd_d;
    end
  end

  assign busy    = busy_q;
  assign frame_q = frm_q;
  assign mdio_o  = busy_q ? cur_bit : 1'b1;
  assign mdio_oe = busy_q && !released;
endmodule

// File: rtl/event_ctrl.sv
module event_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic done,
  input  logic evt_clear,
  input  logic irq_mask,
  output logic evt_flag,
  output logic irq
);
  logic evt_q, evt_d;

  always_comb begin
    evt_d = evt_q;
    if (done) begin
      evt_d = 1'b1;
    end else if (evt_clear) begin
      evt_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= 1'b0;
    end else begin
      evt_q <= evt_d;
    end
  end

  assign evt_flag = evt_q;
  assign irq      = evt_q & irq_mask;
endmodule

// File: rtl/phy_mgmt_master.sv
module phy_mgmt_master
  import mdio_pkg::*;
#(
  parameter int SPEED_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_wr,
  input  logic [31:0]        frame_wdata,
  input  logic [SPEED_W-1:0] speed,
  input  logic               evt_clear,
  input  logic               irq_mask,
  input  logic               mdio_i,
  output logic [31:0]        frame_q,
  output logic               busy,
  output logic               evt_flag,
  output logic               irq,
  output logic               mdc,
  output logic               mdio_o,
  output logic               mdio_oe
);
  logic rise_tick, fall_tick, done, busy_w;

  mdc_gen #(.SPEED_W(SPEED_W)) u_clk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy_w),
    .speed     (speed),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  frame_engine u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (frame_wr),
    .wdata     (frame_wdata),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .mdio_i    (mdio_i),
    .busy      (busy_w),
    .frame_q   (frame_q),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .done      (done)
  );

  event_ctrl u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .evt_clear (evt_clear),
    .irq_mask  (irq_mask),
    .evt_flag  (evt_flag),
    .irq       (irq)
  );

  assign busy = busy_w;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int SPEED_W = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic [SPEED_W-1:0] speed,
  input logic               evt_clear,
  input logic [31:0]        frame_q,
  input logic               busy,
  input logic               evt_flag,
  input logic               mdc,
  input logic               mdio_o,
  input logic               mdio_oe
);
  assert_idle_mdc_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  assert_speed0_mdc_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (speed == '0) |=> !mdc);

  assert_line_stable_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  assert_idle_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  assert_evt_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_flag) |-> $fell(busy));

  assert_evt_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_clear |=> (!evt_flag || $fell(busy)));

  assert_frame_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(frame_q));
endmodule

bind phy_mgmt_master mdio_master_chk #(.SPEED_W(SPEED_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .speed     (speed),
  .evt_clear (evt_clear),
  .frame_q   (frame_q),
  .busy      (busy),
  .evt_flag  (evt_flag),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe)
);

// File: tb/sim_phy_mgmt_master.sv
`timescale 1ns/1ps
module sim_phy_mgmt_master;
  localparam int SW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          frame_wr;
  logic [31:0]   frame_wdata;
  logic [SW-1:0] speed;
  logic          evt_clear;
  logic          irq_mask;
  logic          mdio_i;
  logic [31:0]   frame_q;
  logic          busy, evt_flag, irq, mdc, mdio_o, mdio_oe;

  int nchk = 0;
  int nfail = 0;

  logic [63:0] cap_o, cap_oe;
  int rises, minh, maxh;

  always #5 clk = !clk;

  phy_mgmt_master #(.SPEED_W(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_wr(frame_wr), .frame_wdata(frame_wdata),
    .speed(speed), .evt_clear(evt_clear), .irq_mask(irq_mask), .mdio_i(mdio_i),
    .frame_q(frame_q), .busy(busy), .evt_flag(evt_flag), .irq(irq),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] pa,
                                     input logic [4:0] ra, input logic [15:0] d);
    return {2'b01, op, pa, ra, 2'b10, d};
  endfunction

  task automatic watch(input logic [15:0] pdata, input bit do_poke, input logic [31:0] pw);
    int cyc = 0;
    int last = 0;
    logic prev = mdc;
    bit poking = 1'b0;
    rises = 0; minh = 1000; maxh = 0; cap_o = '0; cap_oe = '0;
    while (busy && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (poking) begin frame_wr = 1'b0; poking = 1'b0; end
      if (mdc !== prev) begin
        if (cyc - last < minh) minh = cyc - last;
        if (cyc - last > maxh) maxh = cyc - last;
        last = cyc;
        prev = mdc;
        if (mdc) begin
          if (rises < 64) begin
            cap_o[63-rises]  = mdio_o;
            cap_oe[63-rises] = mdio_oe;
          end
          rises++;
          if (do_poke && rises == 10) begin
            frame_wdata = pw; frame_wr = 1'b1; poking = 1'b1;
          end
        end else begin
          mdio_i = (rises >= 48 && rises < 64) ? pdata[63-rises] : 1'b1;
        end
      end
    end
    frame_wr = 1'b0;
    mdio_i = 1'b1;
  endtask

  task automatic launch(input logic [31:0] w);
    @(negedge clk);
    frame_wdata = w; frame_wr = 1'b1;
    @(negedge clk);
    frame_wr = 1'b0;
    chk("R2 busy after start", 64'(busy), 64'd1);
  endtask

  task automatic clear_evt();
    @(negedge clk); evt_clear = 1'b1;
    @(negedge clk); evt_clear = 1'b0;
    chk("R7 flag cleared", 64'(evt_flag), 64'd0);
  endtask

  task automatic t_reset();
    chk("R2 busy at reset", 64'(busy), 64'd0);
    chk("R3 mdc low at reset", 64'(mdc), 64'd0);
    chk("R5 oe low at reset", 64'(mdio_oe), 64'd0);
    chk("R7 flag at reset", 64'(evt_flag), 64'd0);
    chk("R8 irq at reset", 64'(irq), 64'd0);
  endtask

  task automatic t_write(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] d,
                         input int s);
    logic [31:0] w = mk(2'b01, pa, ra, d);
    speed = SW'(s); irq_mask = 1'b1;
    launch(w);
    watch(16'h0000, 1'b0, 32'h0);
    chk("R1 bit count", 64'(rises), 64'd64);
    chk("R1 line bits", cap_o, {32'hFFFF_FFFF, w});
    chk("R5 oe on write", cap_oe, {64{1'b1}});
    chk("R3 min half period", 64'(minh), 64'(s));
    chk("R3 max half period", 64'(maxh), 64'(s));
    chk("R6 frame_q after write", 64'(frame_q), 64'(w));
    chk("R7 flag set", 64'(evt_flag), 64'd1);
    chk("R8 irq with mask", 64'(irq), 64'd1);
    chk("R3 mdc low after frame", 64'(mdc), 64'd0);
    clear_evt();
    chk("R8 irq after clear", 64'(irq), 64'd0);
  endtask

  task automatic t_read();
    logic [31:0] w = mk(2'b10, 5'h0A, 5'h13, 16'h0000);
    logic [63:0] eoe = {{46{1'b1}}, 18'h0};
    speed = SW'(2); irq_mask = 1'b0;
    launch(w);
    watch(16'hA5C3, 1'b0, 32'h0);
    chk("R5 oe window on read", cap_oe, eoe);
    chk("R1 driven bits on read", cap_o & eoe, {32'hFFFF_FFFF, w} & eoe);
    chk("R6 read data capture", 64'(frame_q), 64'({w[31:16], 16'hA5C3}));
    chk("R8 flag sets with mask off", 64'(evt_flag), 64'd1);
    chk("R8 irq masked", 64'(irq), 64'd0);
    @(negedge clk); irq_mask = 1'b1; #1;
    chk("R8 irq after unmask", 64'(irq), 64'd1);
    clear_evt();
  endtask

  task automatic t_poke();
    logic [31:0] w  = mk(2'b01, 5'h05, 5'h11, 16'h1234);
    logic [31:0] pw = mk(2'b10, 5'h1A, 5'h0E, 16'hFFFF);
    speed = SW'(2);
    launch(w);
    watch(16'h0000, 1'b1, pw);
    chk("R9 line bits unaffected", cap_o, {32'hFFFF_FFFF, w});
    chk("R9 frame_q unaffected", 64'(frame_q), 64'(w));
    chk("R9 bit count", 64'(rises), 64'd64);
    clear_evt();
  endtask

  task automatic t_stall();
    logic [31:0] w = mk(2'b01, 5'h03, 5'h04, 16'hBEEF);
    int hi = 0;
    speed = '0;
    launch(w);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (mdc) hi++;
    end
    chk("R3 mdc held with speed 0", 64'(hi), 64'd0);
    chk("R2 still busy while stalled", 64'(busy), 64'd1);
    speed = SW'(4);
    watch(16'h0000, 1'b0, 32'h0);
    chk("R3 half period after resume", 64'(maxh), 64'd4);
    chk("R1 bits after resume", cap_o, {32'hFFFF_FFFF, w});
    chk("R7 flag after resume", 64'(evt_flag), 64'd1);
    clear_evt();
  endtask

  initial begin
    #2_000_000;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk + 1, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; frame_wr = 1'b0; frame_wdata = '0; speed = SW'(3);
    evt_clear = 1'b0; irq_mask = 1'b0; mdio_i = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write(5'h1F, 5'h00, 16'hC00D, 3);
    t_write(5'h01, 5'h1E, 16'h0001, 1);
    t_read();
    t_poke();
    t_stall();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule